// File: doc/BRIEF.md
# Segmented Address and Byte-Lane Bus Unit

This unit sits between a requester that thinks in segment:offset pairs and a memory port that is sixteen bits wide. The 16-bit segment is multiplied by sixteen and the 16-bit offset is added to it. The result is a 20-bit physical byte address that wraps around inside a 1 MiB space. The unit then runs one byte or word access on a data bus made of two byte lanes. Even byte addresses use the low lane and odd byte addresses use the high lane.

A word whose physical address is even fits in one bus cycle with both lanes enabled. A word at an odd address is split into two bus cycles:
- The first cycle moves the low byte on the high lane.
- The second cycle goes to the next physical address and moves the high byte on the low lane.

Read data is steered back so that the requester always receives its byte on bits 7:0, or a word in little-endian order. Only one access is in flight at a time. The request port is ready only while nothing is outstanding. Each access ends with a one-cycle response pulse.

Top module: `seg_bus_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0.
- R2: The first bus cycle of an access drives `mem_addr` = (segment × 16 + offset) modulo 2^20.
- R3: A byte access at an even address is one bus cycle with `mem_be` = 2'b01; write data is on bits 7:0 and bits 15:8 are zero; the read result is {8'h00, `mem_rdata`[7:0]}.
- R4: A byte access at an odd address is one bus cycle with `mem_be` = 2'b10; write data is on bits 15:8 and bits 7:0 are zero; the read result is {8'h00, `mem_rdata`[15:8]}.
- R5: A word access at an even address is exactly one bus cycle with `mem_be` = 2'b11. Write data is passed unchanged, and read data is returned unchanged.
- R6: A word access at an odd address A is exactly two bus cycles:
  - First, at A with `mem_be` = 2'b10, carrying write bits 7:0 on lanes 15:8.
  - Then at A+1 with `mem_be` = 2'b01, carrying write bits 15:8 on lanes 7:0.
  - The lane that is not enabled carries zero.
- R7: A split word read returns {second cycle `mem_rdata`[7:0], first cycle `mem_rdata`[15:8]}. The byte from the lower address is the low byte of the result.
- R8: The second-cycle address A+1 wraps modulo 2^20, so a split word at FFFFFh continues at 00000h.
- R9: While `mem_req` is 1 and `mem_ack` is 0, the signals `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values in the next cycle, and `mem_req` stays 1.
- R10: `req_ready` is 0 whenever `mem_req` is 1. A new request is taken only after the last bus cycle of the previous access has been acknowledged. `mem_we` equals the request's write flag in every bus cycle of the access.
- R11: `rsp_valid` pulses for exactly one cycle, in the cycle after the final `mem_ack` of an access. `rsp_rdata` then carries the read result, or zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken on valid and ready |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Aligned read result, zero for writes |
| mem_req | output | 1 | Bus cycle in progress |
| mem_addr | output | 20 | Physical byte address of the bus cycle |
| mem_be | output | 2 | Lane enables, bit 0 = lane 7:0, bit 1 = lane 15:8 |
| mem_we | output | 1 | Bus cycle direction, 1 = write |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_ack | input | 1 | Memory completes the current bus cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
Some properties are checked by assertions in every cycle:
- bus signals hold still while an acknowledge is pending;
- `req_ready` stays low while a bus cycle is open;
- an odd bus address always enables only the high lane;
- the second half of a split word lands on the previous address plus one, with only the low lane enabled;
- the response is a single pulse that follows an acknowledge.

Other properties only the bench scenarios can show. These are the segment arithmetic, including wrap past FFFFFh, the exact lane placement of write bytes, and the little-endian reassembly of split reads under varying acknowledge delays. The bench checks them against a byte-level shadow memory.

// File: rtl/seg_bus_pkg.sv
`timescale 1ns/1ps
package seg_bus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } bus_phase_e;

    localparam int unsigned LANE_COUNT = 2;

endpackage

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] base_w;
    logic [PA_W-1:0] off_w;

    always_comb begin
        base_w = {seg, {SHIFT{1'b0}}};
        off_w  = PA_W'(off);
        // carry beyond the top bit is dropped: the space wraps
        phys   = base_w + off_w;
    end
endmodule

// File: rtl/lane_steer.sv
`timescale 1ns/1ps
module lane_steer #(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              second,
    input  logic              word,
    input  logic              odd,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        be,
    output logic [DATA_W-1:0] lane_data
);
    logic [LANE_W-1:0] byte_lo;
    logic [LANE_W-1:0] byte_hi;
    logic [LANE_W-1:0] src [2];

    always_comb begin
        byte_lo = wdata[LANE_W-1:0];
        byte_hi = wdata[DATA_W-1:LANE_W];
        if (second) begin
            be     = 2'b01;
            src[0] = byte_hi;
            src[1] = byte_lo;
        end else if (word && !odd) begin
            be     = 2'b11;
            src[0] = byte_lo;
            src[1] = byte_hi;
        end else if (odd) begin
            be     = 2'b10;
            src[0] = byte_hi;
            src[1] = byte_lo;
        end else begin
            be     = 2'b01;
            src[0] = byte_lo;
            src[1] = byte_hi;
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_lane
        assign lane_data[k*LANE_W +: LANE_W] = be[k] ? src[k] : '0;
    end
endmodule

// File: rtl/read_align.sv
`timescale 1ns/1ps
module read_align #(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              second,
    input  logic              word,
    input  logic              odd,
    input  logic [LANE_W-1:0] lo_hold,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    logic [LANE_W-1:0] lane_lo;
    logic [LANE_W-1:0] lane_hi;

    always_comb begin
        lane_lo = rdata[LANE_W-1:0];
        lane_hi = rdata[DATA_W-1:LANE_W];
        if (second) begin
            data = {lane_lo, lo_hold};
        end else if (word && !odd) begin
            data = rdata;
        end else if (odd) begin
            data = {{LANE_W{1'b0}}, lane_hi};
        end else begin
            data = {{LANE_W{1'b0}}, lane_lo};
        end
    end
endmodule

// File: rtl/seg_bus_unit.sv
`timescale 1ns/1ps
module seg_bus_unit
    import seg_bus_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int LANE_W = 8,
    localparam int PA_W   = SEG_W + SHIFT,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    output logic [1:0]        mem_be,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    typedef struct packed {
        bus_phase_e        phase;
        logic [PA_W-1:0]   addr;
        logic              word;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [LANE_W-1:0] lo_hold;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } ctrl_t;

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    logic [PA_W-1:0]   phys;
    logic              in_second;
    logic              odd_addr;
    logic              split_word;
    logic [1:0]        lane_be;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] aligned_rd;

    seg_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_addr_gen (
        .seg  (req_seg),
        .off  (req_off),
        .phys (phys)
    );

    assign in_second  = (ctrl_q.phase == PH_SECOND);
    assign odd_addr   = ctrl_q.addr[0];
    assign split_word = ctrl_q.word && odd_addr;

    lane_steer #(
        .LANE_W (LANE_W)
    ) u_lane_steer (
        .second    (in_second),
        .word      (ctrl_q.word),
        .odd       (odd_addr),
        .wdata     (ctrl_q.wdata),
        .be        (lane_be),
        .lane_data (lane_wdata)
    );

    read_align #(
        .LANE_W (LANE_W)
    ) u_read_align (
        .second  (in_second),
        .word    (ctrl_q.word),
        .odd     (odd_addr),
        .lo_hold (ctrl_q.lo_hold),
        .rdata   (mem_rdata),
        .data    (aligned_rd)
    );

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.rsp_valid = 1'b0;
        unique case (ctrl_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    ctrl_d.addr  = phys;
                    ctrl_d.word  = req_word;
                    ctrl_d.write = req_write;
                    ctrl_d.wdata = req_wdata;
                    ctrl_d.phase = PH_FIRST;
                end
            end
            PH_FIRST: begin
                if (mem_ack) begin
                    if (split_word) begin
                        ctrl_d.lo_hold = mem_rdata[DATA_W-1:LANE_W];
                        ctrl_d.addr    = ctrl_q.addr + PA_W'(1);
                        ctrl_d.phase   = PH_SECOND;
                    end else begin
                        ctrl_d.rsp_valid = 1'b1;
                        ctrl_d.rsp_data  = ctrl_q.write ? '0 : aligned_rd;
                        ctrl_d.phase     = PH_IDLE;
                    end
                end
            end
            PH_SECOND: begin
                if (mem_ack) begin
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_data  = ctrl_q.write ? '0 : aligned_rd;
                    ctrl_d.phase     = PH_IDLE;
                end
            end
            default: begin
                ctrl_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready = (ctrl_q.phase == PH_IDLE);
    assign mem_req   = (ctrl_q.phase != PH_IDLE);
    assign mem_addr  = ctrl_q.addr;
    assign mem_be    = lane_be;
    assign mem_we    = ctrl_q.write;
    assign mem_wdata = lane_wdata;
    assign rsp_valid = ctrl_q.rsp_valid;
    assign rsp_rdata = ctrl_q.rsp_data;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R10

    AST_ODD_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_addr[0]) |-> (mem_be == 2'b10)); // R4

    AST_SPLIT_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.phase == PH_FIRST && split_word && mem_ack)
        |=> (mem_req && mem_be == 2'b01 && mem_addr == PA_W'($past(mem_addr) + 1'b1))); // R8

    AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(mem_req) && $past(mem_ack))); // R11

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11

endmodule

// File: tb/test_seg_bus_unit.sv
`timescale 1ns/1ps
module test_seg_bus_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic [1:0]  mem_be;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    seg_bus_unit i_seg_bus_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_word(req_word),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct {
        logic [19:0] a;
        logic [1:0]  be;
        logic        we;
        logic [15:0] wd;
        string       tag;
    } bus_item_t;

    typedef struct {
        logic [15:0] d;
        string       tag;
    } rsp_item_t;

    bus_item_t bus_q[$];
    rsp_item_t rsp_q[$];
    logic [7:0] model_mem [int];
    logic [7:0] shadow [int];

    int checks = 0;
    int fails  = 0;
    int wait_left = 0;
    logic [7:0] lf = 8'h5B;
    logic prev_rsp = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input int a);
        return model_mem.exists(a) ? model_mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        bus_item_t it;
        rsp_item_t ri;
        int base;
        mem_ack   = 1'b0;
        mem_rdata = 16'hA5A5;
        if (rst_n && mem_req) begin
            if (bus_q.size() == 0) begin
                chk("R5", "unexpected bus cycle", 32'(mem_addr), 32'hFFFFFFFF);
            end else if (wait_left != 0) begin
                wait_left--;
                chk("R9", "addr held while waiting", 32'(mem_addr), 32'(bus_q[0].a));
                chk("R10", "ready low while busy", 32'(req_ready), 32'd0);
            end else begin
                it = bus_q.pop_front();
                chk(it.tag, "bus address", 32'(mem_addr), 32'(it.a));
                chk(it.tag, "lane enables", 32'(mem_be), 32'(it.be));
                chk("R10", "direction", 32'(mem_we), 32'(it.we));
                if (it.we) chk(it.tag, "lane write data", 32'(mem_wdata), 32'(it.wd));
                base = int'({mem_addr[19:1], 1'b0});
                if (mem_we) begin
                    if (mem_be[0]) model_mem[base]     = mem_wdata[7:0];
                    if (mem_be[1]) model_mem[base + 1] = mem_wdata[15:8];
                end else begin
                    if (mem_be[0]) mem_rdata[7:0]  = model_rd(base);
                    if (mem_be[1]) mem_rdata[15:8] = model_rd(base + 1);
                end
                mem_ack   = 1'b1;
                lf        = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                wait_left = int'(lf % 8'd3);
            end
        end
        if (rst_n && rsp_valid) begin
            chk("R11", "single-cycle pulse", 32'(prev_rsp), 32'd0);
            chk("R11", "all bus cycles done", 32'(bus_q.size()), 32'd0);
            if (rsp_q.size() == 0) begin
                chk("R11", "unexpected response", 32'd1, 32'd0);
            end else begin
                ri = rsp_q.pop_front();
                chk(ri.tag, "response data", 32'(rsp_rdata), 32'(ri.d));
            end
        end
        prev_rsp = rst_n && rsp_valid;
    end

    task automatic access(input logic [15:0] seg, input logic [15:0] off,
                          input bit word, input bit write,
                          input logic [15:0] wd, input string tag);
        logic [19:0] pa;
        logic [19:0] pa1;
        logic [15:0] exp_d;
        pa  = {seg, 4'h0} + {4'h0, off};
        pa1 = pa + 20'd1;
        if (word && pa[0]) begin
            bus_q.push_back('{pa,  2'b10, write, {wd[7:0], 8'h00}, tag});
            bus_q.push_back('{pa1, 2'b01, write, {8'h00, wd[15:8]}, tag});
            exp_d = {shadow_rd(int'(pa1)), shadow_rd(int'(pa))};
        end else if (word) begin
            bus_q.push_back('{pa, 2'b11, write, wd, tag});
            exp_d = {shadow_rd(int'(pa1)), shadow_rd(int'(pa))};
        end else begin
            if (pa[0]) bus_q.push_back('{pa, 2'b10, write, {wd[7:0], 8'h00}, tag});
            else       bus_q.push_back('{pa, 2'b01, write, {8'h00, wd[7:0]}, tag});
            exp_d = {8'h00, shadow_rd(int'(pa))};
        end
        if (write) begin
            shadow[int'(pa)] = wd[7:0];
            if (word) shadow[int'(pa1)] = wd[15:8];
            exp_d = 16'h0000;
        end
        rsp_q.push_back('{exp_d, tag});
        @(negedge clk);
        chk("R10", "ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_seg   = seg;
        req_off   = off;
        req_word  = word;
        req_write = write;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 16'hDEAD;
        while (rsp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", 32'(req_ready), 32'd1);
        chk("R1", "no bus cycle in reset", 32'(mem_req), 32'd0);
        chk("R1", "no response in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "idle bus after reset", 32'(mem_req), 32'd0);

        // aligned word at A4FB:4872 -> A9822 (R2, R5)
        access(16'hA4FB, 16'h4872, 1'b1, 1'b1, 16'hBEEF, "R2/R5");
        access(16'hA4FB, 16'h4872, 1'b1, 1'b0, 16'h0000, "R5");
        // bytes on both lanes
        access(16'h1000, 16'h0029, 1'b0, 1'b1, 16'h7755, "R4");
        access(16'h1000, 16'h0028, 1'b0, 1'b1, 16'h8866, "R3");
        access(16'h1000, 16'h0029, 1'b0, 1'b0, 16'h0000, "R4");
        access(16'h1000, 16'h0028, 1'b0, 1'b0, 16'h0000, "R3");
        access(16'h1000, 16'h0028, 1'b1, 1'b0, 16'h0000, "R5");
        // split word
        access(16'h2000, 16'h0003, 1'b1, 1'b1, 16'h1234, "R6");
        access(16'h2000, 16'h0003, 1'b1, 1'b0, 16'h0000, "R7");
        access(16'h2000, 16'h0004, 1'b0, 1'b0, 16'h0000, "R7");
        access(16'h1FFF, 16'h0013, 1'b0, 1'b0, 16'h0000, "R7");
        // wrap of the top of space
        access(16'hF000, 16'hFFFF, 1'b1, 1'b1, 16'hCAFE, "R8");
        access(16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, "R8");
        access(16'hFFFF, 16'h0010, 1'b0, 1'b0, 16'h0000, "R2/R8");
        access(16'hFFFF, 16'h000F, 1'b1, 1'b0, 16'h0000, "R8");
        // mixed patterns
        for (int i = 1; i <= 24; i++) begin
            access(16'(i * 16'h0123), 16'(i * 16'h01F3), (i % 2) == 1,
                   (i % 3) != 0, 16'(i * 16'h3B5D), "R2");
            access(16'(i * 16'h0123), 16'(i * 16'h01F3), 1'b1, 1'b0,
                   16'h0000, "R7");
        end
        repeat (3) @(negedge clk);
        chk("R11", "no leftover responses", 32'(rsp_q.size()), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule